// File: doc/BRIEF.md
# Speculative Return Address Stack

This block predicts the targets of return instructions for a fetch pipeline. A call pushes the address of the instruction that follows it. A return reads its predicted target from the top entry and pops that entry. Every other branch only records state. Fetch runs ahead of branch resolution, so pushes and pops can happen on a wrong path. Each accepted fetch operation therefore takes a checkpoint. The checkpoint holds the stack pointer and the top entry as they stood just before the operation.

When a misprediction is resolved, the branch unit names the checkpoint of the mispredicted operation. The block then writes back the saved pointer and top entry in one cycle. That checkpoint and every younger one are discarded. If the named checkpoint has already been freed, the state cannot be rebuilt. The block then clears every entry's valid bit and resets the pointer. From then on, returns get no prediction until new calls have refilled the stack.

Checkpoints retire in order through a separate commit stream. A call whose target is the very next instruction is pushed like any other call. The stack is circular: an overflow overwrites the oldest entry. Two streams use valid/ready. A fetch operation is taken only when `op_valid` and `op_ready` are both high. A commit is taken only when `commit_valid` and `commit_ready` are both high. Either producer must hold its request until it is taken.

Top module: `ras_predictor`

## Requirements
- R1: After reset, `op_ready` and `commit_ready` are 1, and a return gets `pred_valid` = 0.
- R2: An accepted call (`op_kind` = 2'b01) pushes `op_ret_addr`, whatever that address is, including the address of the call's own target. The next return predicts that address.
- R3: An accepted return (`op_kind` = 2'b10) drives `pred_valid` = 1 and `pred_target` = the top entry in the same cycle, then pops it, so returns predict in last-in first-out order. A plain branch (`op_kind` = 2'b00) neither pushes nor pops.
- R4: A return on an empty top entry gives `pred_valid` = 0 and leaves the stack pointer unchanged.
- R5: With 16 entries, 17 calls followed by 17 returns predict the last 16 call addresses, newest first. The 17th return gives `pred_valid` = 0.
- R6: Each accepted operation gets `op_tag`, which is one greater (mod 8) than the previous tag. `op_ready` is 0 while all 8 checkpoints are live.
- R7: A restore (`fix_valid`) naming a live tag brings back the stack pointer and the top entry saved just before that operation. The next return then predicts the value saved there.
- R8: A restore frees the named tag and every younger tag.
- R9: A restore naming a freed tag invalidates the whole stack. Returns give `pred_valid` = 0 until a new call is pushed.
- R10: A commit frees the oldest live tag. A later restore naming that tag invalidates the stack.
- R11: While `fix_valid` is 1, `op_ready` and `commit_ready` are 0, and neither stream is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Fetch operation present |
| op_ready | output | 1 | Fetch operation can be taken |
| op_kind | input | 2 | 00 branch, 01 call, 10 return, 11 treated as branch |
| op_ret_addr | input | ADDR_W | Address after the call |
| op_tag | output | TAG_W | Checkpoint tag given to the taken operation |
| pred_valid | output | 1 | Return target prediction is valid |
| pred_target | output | ADDR_W | Predicted return target |
| commit_valid | input | 1 | Retire the oldest checkpoint |
| commit_ready | output | 1 | Commit can be taken |
| fix_valid | input | 1 | Misprediction restore request |
| fix_tag | input | TAG_W | Checkpoint to restore |

## Verification
A restore and a new fetch operation or commit can arrive in the same cycle. The restore wins, and the other requests are held back through their ready signals. The bench provokes this by raising `fix_valid` together with a call and a commit. It checks that both ready signals are low in that cycle. A later return then shows that neither the held call nor the restored-away push is on the stack. The bench also places a restore straight after wrong-path pushes that followed a pop. The repaired top entry must be predicted again.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_BR   = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_RSV  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/ras_stack.sv
// Circular storage of return addresses with per-entry valid bits.
module ras_stack #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              restore,
  input  logic [PTR_W-1:0]  rs_ptr,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic              rs_vld,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [ADDR_W-1:0] top_val,
  output logic              top_vld
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptr_up;
  logic [PTR_W-1:0]  ptr_dn;
  logic              pop_take;

  assign ptr_up   = ptr + PTR_W'(1);
  assign ptr_dn   = ptr - PTR_W'(1);
  assign pop_take = pop && vld[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      vld <= '0;
    end else if (flush) begin
      ptr <= '0;
      vld <= '0;
    end else if (restore) begin
      ptr         <= rs_ptr;
      vld[rs_ptr] <= rs_vld;
    end else if (push) begin
      ptr         <= ptr_up;
      vld[ptr_up] <= 1'b1;
    end else if (pop_take) begin
      ptr      <= ptr_dn;
      vld[ptr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush) begin
      if (restore) begin
        mem[rs_ptr] <= rs_val;
      end else if (push) begin
        mem[ptr_up] <= push_addr;
      end
    end
  end

  assign top_ptr = ptr;
  assign top_val = mem[ptr];
  assign top_vld = vld[ptr];
endmodule

// File: rtl/ras_ckpt.sv
// Ring of in-order checkpoints: pointer, top value and top valid bit.
module ras_ckpt #(
  parameter int TAG_W  = 3,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 32,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic [ADDR_W-1:0] in_val,
  input  logic              in_vld,
  input  logic              retire,
  input  logic              fix,
  input  logic [TAG_W-1:0]  fix_tag,
  output logic [TAG_W-1:0]  head_tag,
  output logic              full,
  output logic              fix_live,
  output logic [PTR_W-1:0]  out_ptr,
  output logic [ADDR_W-1:0] out_val,
  output logic              out_vld
);
  logic [PTR_W-1:0]  sv_ptr [SLOTS];
  logic [ADDR_W-1:0] sv_val [SLOTS];
  logic [SLOTS-1:0]  sv_vld;
  logic [SLOTS-1:0]  live, live_nx, kill;
  logic [TAG_W-1:0]  head, tail, head_nx, tail_nx, span;
  logic              retire_take;

  assign span        = head - fix_tag;
  assign retire_take = retire && live[tail];

  for (genvar g = 0; g < SLOTS; g++) begin : g_kill
    assign kill[g] = (span == '0) || ((TAG_W'(g) - fix_tag) < span);
  end

  always_comb begin
    live_nx = live;
    head_nx = head;
    tail_nx = tail;
    if (fix) begin
      if (live[fix_tag]) begin
        live_nx = live & ~kill;
        head_nx = fix_tag;
      end else begin
        live_nx = '0;
        head_nx = '0;
        tail_nx = '0;
      end
    end else begin
      if (alloc) begin
        live_nx[head] = 1'b1;
        head_nx       = head + TAG_W'(1);
      end
      if (retire_take) begin
        live_nx[tail] = 1'b0;
        tail_nx       = tail + TAG_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      head <= '0;
      tail <= '0;
    end else begin
      live <= live_nx;
      head <= head_nx;
      tail <= tail_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc && !fix) begin
      sv_ptr[head] <= in_ptr;
      sv_val[head] <= in_val;
      sv_vld[head] <= in_vld;
    end
  end

  assign head_tag = head;
  assign full     = live[head];
  assign fix_live = live[fix_tag];
  assign out_ptr  = sv_ptr[fix_tag];
  assign out_val  = sv_val[fix_tag];
  assign out_vld  = sv_vld[fix_tag];
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_ret_addr,
  output logic [TAG_W-1:0]  op_tag,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              commit_valid,
  output logic              commit_ready,
  input  logic              fix_valid,
  input  logic [TAG_W-1:0]  fix_tag
);
  import ras_pkg::*;

  logic              accept, is_call, is_ret;
  logic              restore, flush, ck_full, ck_live;
  logic [PTR_W-1:0]  top_ptr, ck_ptr;
  logic [ADDR_W-1:0] top_val, ck_val;
  logic              top_vld, ck_vld;

  assign is_call      = op_kind == OP_CALL;
  assign is_ret       = op_kind == OP_RET;
  assign op_ready     = !fix_valid && !ck_full;
  assign commit_ready = !fix_valid;
  assign accept       = op_valid && op_ready;
  assign restore      = fix_valid && ck_live;
  assign flush        = fix_valid && !ck_live;

  ras_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .restore   (restore),
    .rs_ptr    (ck_ptr),
    .rs_val    (ck_val),
    .rs_vld    (ck_vld),
    .push      (accept && is_call),
    .push_addr (op_ret_addr),
    .pop       (accept && is_ret),
    .top_ptr   (top_ptr),
    .top_val   (top_val),
    .top_vld   (top_vld)
  );

  ras_ckpt #(.TAG_W(TAG_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ckpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (accept),
    .in_ptr   (top_ptr),
    .in_val   (top_val),
    .in_vld   (top_vld),
    .retire   (commit_valid && commit_ready),
    .fix      (fix_valid),
    .fix_tag  (fix_tag),
    .head_tag (op_tag),
    .full     (ck_full),
    .fix_live (ck_live),
    .out_ptr  (ck_ptr),
    .out_val  (ck_val),
    .out_vld  (ck_vld)
  );

  assign pred_valid  = accept && is_ret && top_vld;
  assign pred_target = top_val;
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 4,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_ret_addr,
  input logic [TAG_W-1:0]  op_tag,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_target,
  input logic              commit_ready,
  input logic              fix_valid,
  input logic              accept,
  input logic              restore,
  input logic              flush,
  input logic              ck_full,
  input logic [PTR_W-1:0]  ck_ptr,
  input logic [ADDR_W-1:0] ck_val,
  input logic [PTR_W-1:0]  top_ptr,
  input logic [ADDR_W-1:0] top_val,
  input logic              top_vld
);
  import ras_pkg::*;

  a_r11_fix_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |-> (!op_ready && !commit_ready));

  a_r3_pred_only_ret: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (op_valid && op_ready && op_kind == OP_RET));

  a_r2_call_then_ret: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accept && op_kind == OP_CALL) && accept && op_kind == OP_RET)
      |-> (pred_valid && pred_target == $past(op_ret_addr)));

  a_r4_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == OP_RET && !top_vld) |=> $stable(top_ptr));

  a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ck_full |-> !op_ready);

  a_r6_tag_order: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (accept |-> op_tag == $past(op_tag) + TAG_W'(1)));

  a_r7_restore_state: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (top_ptr == $past(ck_ptr) && top_val == $past(ck_val)));

  a_r9_flush_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !top_vld && !pred_valid);
endmodule

bind ras_predictor ras_predictor_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .op_kind      (op_kind),
  .op_ret_addr  (op_ret_addr),
  .op_tag       (op_tag),
  .pred_valid   (pred_valid),
  .pred_target  (pred_target),
  .commit_ready (commit_ready),
  .fix_valid    (fix_valid),
  .accept       (accept),
  .restore      (restore),
  .flush        (flush),
  .ck_full      (ck_full),
  .ck_ptr       (ck_ptr),
  .ck_val       (ck_val),
  .top_ptr      (top_ptr),
  .top_val      (top_val),
  .top_vld      (top_vld)
);

// File: tb/test_ras_predictor.sv
module test_ras_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 3;
  localparam logic [1:0] K_BR = 2'b00, K_CALL = 2'b01, K_RET = 2'b10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic        epv;
    logic [31:0] etgt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{K_RET,  32'h0,   1'b0, 32'h0},
    '{K_CALL, 32'h100, 1'b0, 32'h0},
    '{K_CALL, 32'h200, 1'b0, 32'h0},
    '{K_BR,   32'h0,   1'b0, 32'h0},
    '{K_RET,  32'h0,   1'b1, 32'h200},
    '{K_CALL, 32'h300, 1'b0, 32'h0},
    '{K_RET,  32'h0,   1'b1, 32'h300},
    '{K_RET,  32'h0,   1'b1, 32'h100},
    '{K_RET,  32'h0,   1'b0, 32'h0},
    '{K_CALL, 32'h104, 1'b0, 32'h0},
    '{K_CALL, 32'h200, 1'b0, 32'h0},
    '{K_RET,  32'h0,   1'b1, 32'h200},
    '{K_RET,  32'h0,   1'b1, 32'h104}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic              op_ready;
  logic [1:0]        op_kind = K_BR;
  logic [ADDR_W-1:0] op_ret_addr = '0;
  logic [TAG_W-1:0]  op_tag;
  logic              pred_valid;
  logic [ADDR_W-1:0] pred_target;
  logic              commit_valid = 1'b0;
  logic              commit_ready;
  logic              fix_valid = 1'b0;
  logic [TAG_W-1:0]  fix_tag = '0;

  int errors = 0;
  int checks = 0;
  logic [TAG_W-1:0] last_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_predictor #(.DEPTH(16), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_ras_predictor (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_ret_addr(op_ret_addr), .op_tag(op_tag),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .fix_valid(fix_valid), .fix_tag(fix_tag)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One fetch operation; outputs sampled before the clock edge that takes it.
  task automatic op(input logic [1:0] k, input logic [31:0] a, input logic epv,
                    input logic [31:0] et, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_ret_addr = a;
    #1;
    last_tag = op_tag;
    check(op_ready == 1'b1, {req, " ready"}, 64'(op_ready), 64'd1);
    check(pred_valid == epv, {req, " pred_valid"}, 64'(pred_valid), 64'(epv));
    if (epv) check(pred_target == et, {req, " pred_target"}, 64'(pred_target), 64'(et));
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    commit_valid = 1'b1;
    repeat (n) @(posedge clk);
    #1 commit_valid = 1'b0;
  endtask

  task automatic fix(input logic [TAG_W-1:0] t, input string req);
    @(negedge clk);
    fix_valid = 1'b1; fix_tag = t;
    #1;
    check(op_ready == 1'b0, {req, " op_ready in fix"}, 64'(op_ready), 64'd0);
    @(posedge clk); #1;
    fix_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] t0, tr, t2, td;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(op_ready == 1'b1, "R1 op_ready", 64'(op_ready), 64'd1);
    check(commit_ready == 1'b1, "R1 commit_ready", 64'(commit_ready), 64'd1);

    // Table walk: R1, R2, R3, R4 (row 0 and 8), R2 call-to-next (0x104)
    commit_valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].kind, VEC[i].addr, VEC[i].epv, VEC[i].etgt, $sformatf("R3 table row %0d", i));
    end
    commit_valid = 1'b0;
    idle(3);

    // R5 overflow wrap
    commit_valid = 1'b1;
    for (int i = 1; i <= 17; i++) op(K_CALL, 32'h1000 + 32'(i*4), 1'b0, 32'h0, "R5 call");
    for (int i = 17; i >= 2; i--) op(K_RET, 32'h0, 1'b1, 32'h1000 + 32'(i*4), "R5 ret");
    op(K_RET, 32'h0, 1'b0, 32'h0, "R5 ret past oldest");
    commit_valid = 1'b0;
    idle(4);

    // R6 tag order and full stall
    op(K_BR, 32'h0, 1'b0, 32'h0, "R6 br");
    t0 = last_tag;
    for (int i = 1; i < 8; i++) begin
      op(K_BR, 32'h0, 1'b0, 32'h0, "R6 br");
      check(last_tag == t0 + TAG_W'(i), "R6 tag order", 64'(last_tag), 64'(t0 + TAG_W'(i)));
    end
    @(negedge clk); #1;
    check(op_ready == 1'b0, "R6 full stall", 64'(op_ready), 64'd0);
    idle(1);
    @(negedge clk); #1;
    check(op_ready == 1'b1, "R6 ready after commit", 64'(op_ready), 64'd1);
    idle(9);

    // R7 repair after wrong-path pushes, R8 younger tags freed, R9 invalidation
    op(K_CALL, 32'hA0, 1'b0, 32'h0, "R7 call");
    op(K_RET,  32'h0,  1'b1, 32'hA0, "R7 ret");
    tr = last_tag;
    op(K_CALL, 32'hB0, 1'b0, 32'h0, "R7 wrong call");
    op(K_CALL, 32'hC0, 1'b0, 32'h0, "R7 wrong call");
    fix(tr, "R7");
    op(K_RET, 32'h0, 1'b1, 32'hA0, "R7 repaired ret");
    check(last_tag == tr, "R8 tag reused", 64'(last_tag), 64'(tr));
    fix(tr + TAG_W'(1), "R8");
    op(K_RET, 32'h0, 1'b0, 32'h0, "R9 invalidated ret");
    op(K_CALL, 32'hE0, 1'b0, 32'h0, "R9 refill call");
    op(K_RET, 32'h0, 1'b1, 32'hE0, "R9 refilled ret");
    idle(9);

    // R10 commit frees oldest; restore of committed tag invalidates
    op(K_CALL, 32'h40, 1'b0, 32'h0, "R10 call");
    idle(1);
    op(K_CALL, 32'h50, 1'b0, 32'h0, "R10 call");
    t2 = last_tag;
    idle(1);
    fix(t2, "R10");
    op(K_RET, 32'h0, 1'b0, 32'h0, "R10 ret after stale restore");
    idle(9);

    // R11 restore collides with a call and a commit
    op(K_CALL, 32'h60, 1'b0, 32'h0, "R11 call");
    td = last_tag;
    @(negedge clk);
    fix_valid = 1'b1; fix_tag = td;
    op_valid = 1'b1; op_kind = K_CALL; op_ret_addr = 32'hF0;
    commit_valid = 1'b1;
    #1;
    check(op_ready == 1'b0, "R11 op_ready", 64'(op_ready), 64'd0);
    check(commit_ready == 1'b0, "R11 commit_ready", 64'(commit_ready), 64'd0);
    check(pred_valid == 1'b0, "R11 no pred", 64'(pred_valid), 64'd0);
    @(posedge clk); #1;
    fix_valid = 1'b0; op_valid = 1'b0; commit_valid = 1'b0;
    op(K_RET, 32'h0, 1'b0, 32'h0, "R11 held call not pushed");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule